// File: doc/BRIEF.md
# Serial Shift-Add Multiply-Accumulate Unit

This unit accumulates products of an activation and a weight without a parallel multiplier. Each product is formed on one shared adder over several clock cycles. One operand is split into its set bits, and for each set bit the other operand, shifted to that bit's weight, is added to or subtracted from a running sum. Bits that are zero cost no cycle. For every pair the unit picks the operand with fewer set bits as the one to split, so each pair takes as few cycles as possible.

The operand width is chosen per layer at run time, and one datapath serves every width from 1 to 8 bits. An approximation level lets the unit leave out the least significant set bits of the split operand. This trades accuracy for fewer cycles. Operands are unsigned magnitudes, and a separate sign input chooses between adding and subtracting the product. A pair is accepted only while `ready` is high. `done` marks the end of each pair's work, and a start-of-sum flag that travels with a pair restarts the sum from zero.

Top module: `shift_add_mac`

## Requirements
- R1: In exact mode (approximation level 0), each accepted pair changes the 24-bit two's-complement sum by +act*wgt when `signIn`=0 and by -act*wgt when `signIn`=1, wrapping modulo 2^24.
- R2: A pair whose split operand keeps k>0 set bits takes exactly k add cycles. `ready` is low from the edge that accepts the pair until the edge of the k-th add, and it is high again in the cycle after that add.
- R3: The operand split into additions is the one with fewer set bits after width masking. When the counts are equal, the weight is split.
- R4: Only bit positions below the width setting `layerWidth` take part in either operand. Higher bits are treated as zero. A setting of 0 or above 8 selects the full 8 bits.
- R5: An approximation level N removes the N least significant set bits of the split operand. The sum changes by ±(trimmed operand × other operand), and the pair takes max(0, k-N) add cycles. The operand is chosen using the counts before trimming.
- R6: If either masked operand is zero, or trimming leaves no set bit, the pair takes no add cycle. `done` is high right after the accepting edge, `ready` stays high, and the sum is unchanged apart from R7.
- R7: When `startSum` is high on the accepting edge, the sum is cleared before that pair's product is applied.
- R8: `done` is high for the single cycle after a pair's final add (see R6 for pairs that take no add). `accOut` holds its value between pairs. `inValid` has no effect while `ready` is low.
- R9: After reset, `accOut` is 0, `ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair is offered this cycle |
| actIn | input | 8 | Activation magnitude |
| wgtIn | input | 8 | Weight magnitude |
| signIn | input | 1 | 1 = subtract the product, 0 = add it |
| startSum | input | 1 | Clear the sum before this pair |
| layerWidth | input | 4 | Operand width in bits (0 or >8 means 8) |
| approxLvl | input | 3 | Number of low set bits of the split operand to drop |
| ready | output | 1 | Unit can accept a pair |
| done | output | 1 | One-cycle marker that a pair finished |
| accOut | output | 24 | Running sum, two's complement |

## Verification
A pair's result becomes visible after the accepting edge plus k further edges, where k is the number of adds that pair needs. Pairs that need no add finish on the accepting edge itself. The driver records the cycle number of each accepting edge and queues the expected sum together with the expected add count. The monitor samples on falling edges: each time `done` is seen, it checks that the cycle number equals the accept cycle plus k and compares the sum. One falling edge after acceptance, the driver also checks that `ready` is low exactly when k is greater than zero.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int MAC_OP_W = 8;
  localparam int MAC_SH_W = $clog2(MAC_OP_W);

  typedef struct packed {
    logic                load;
    logic                clear;
    logic                add;
    logic [MAC_SH_W-1:0] shift;
  } mac_strobe_t;
endpackage

// File: rtl/mac_select.sv
module mac_select #(
  parameter int OP_W = 8,
  parameter int WD_W = $clog2(OP_W) + 1,
  parameter int AP_W = $clog2(OP_W)
) (
  input  logic [OP_W-1:0] actIn,
  input  logic [OP_W-1:0] wgtIn,
  input  logic [WD_W-1:0] layerWidth,
  input  logic [AP_W-1:0] approxLvl,
  output logic [OP_W-1:0] decompMask,
  output logic [OP_W-1:0] multiplicand,
  output logic            skip
);
  logic [OP_W-1:0] keepMask, actM, wgtM, chosen, trimmed;
  int effWidth, actCnt, wgtCnt, dropped;

  always_comb begin
    if (layerWidth == '0 || int'(layerWidth) > OP_W) effWidth = OP_W;
    else effWidth = int'(layerWidth);
    for (int i = 0; i < OP_W; i++) keepMask[i] = (i < effWidth);
    actM = actIn & keepMask;
    wgtM = wgtIn & keepMask;
    actCnt = 0;
    wgtCnt = 0;
    for (int i = 0; i < OP_W; i++) begin
      actCnt += int'(actM[i]);
      wgtCnt += int'(wgtM[i]);
    end
    // Tie goes to the weight.
    if (actCnt < wgtCnt) begin
      chosen = actM;
      multiplicand = wgtM;
    end else begin
      chosen = wgtM;
      multiplicand = actM;
    end
    trimmed = chosen;
    dropped = 0;
    for (int i = 0; i < OP_W; i++) begin
      if (chosen[i] && dropped < int'(approxLvl)) begin
        trimmed[i] = 1'b0;
        dropped++;
      end
    end
    decompMask = trimmed;
    skip = (actM == '0) || (wgtM == '0) || (trimmed == '0);
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int OP_W = MAC_OP_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            startSum,
  input  logic            skip,
  input  logic [OP_W-1:0] decompMask,
  output logic            ready,
  output logic            done,
  output mac_strobe_t     stb
);
  logic            busy;
  logic [OP_W-1:0] remMask, topBit, restMask;
  logic [MAC_SH_W-1:0] topIdx;
  logic            accept, lastAdd;

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < OP_W; i++)
      if (remMask[i]) topIdx = MAC_SH_W'(i);
    topBit   = OP_W'(1) << topIdx;
    restMask = remMask & ~topBit;
    lastAdd  = (restMask == '0);
  end

  assign accept    = inValid && !busy;
  assign ready     = !busy;
  assign stb.load  = accept;
  assign stb.clear = accept && startSum;
  assign stb.add   = busy;
  assign stb.shift = topIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      remMask <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (skip) done <= 1'b1;
        else begin
          busy    <= 1'b1;
          remMask <= decompMask;
        end
      end else if (busy) begin
        remMask <= restMask;
        if (lastAdd) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: each add consumes exactly one set bit
  p_one_bit_per_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastAdd |=> busy && ($countones(remMask) == $countones($past(remMask)) - 1));
  // R2: ready and done follow the final add
  p_ready_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && lastAdd |=> ready && done);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W  = MAC_OP_W,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  mac_strobe_t      stb,
  input  logic [OP_W-1:0]  multiplicand,
  input  logic             signIn,
  output logic [ACC_W-1:0] accOut
);
  logic [OP_W-1:0]  multReg;
  logic             negReg;
  logic [ACC_W-1:0] addend;

  assign addend = {{(ACC_W-OP_W){1'b0}}, multReg} << stb.shift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      multReg <= '0;
      negReg  <= 1'b0;
      accOut  <= '0;
    end else if (stb.load) begin
      multReg <= multiplicand;
      negReg  <= signIn;
      if (stb.clear) accOut <= '0;
    end else if (stb.add) begin
      accOut <= negReg ? accOut - addend : accOut + addend;
    end
  end

  // R8: sum holds when nothing is added or cleared
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.add && !stb.clear |=> $stable(accOut));
  // R7: start-of-sum clears the accumulator
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> accOut == '0);
endmodule

// File: rtl/shift_add_mac.sv
module shift_add_mac
  import mac_pkg::*;
#(
  parameter int OP_W  = MAC_OP_W,
  parameter int ACC_W = 24,
  localparam int WD_W = $clog2(OP_W) + 1,
  localparam int AP_W = $clog2(OP_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  actIn,
  input  logic [OP_W-1:0]  wgtIn,
  input  logic             signIn,
  input  logic             startSum,
  input  logic [WD_W-1:0]  layerWidth,
  input  logic [AP_W-1:0]  approxLvl,
  output logic             ready,
  output logic             done,
  output logic [ACC_W-1:0] accOut
);
  logic [OP_W-1:0] decompMask, multiplicand;
  logic            skip;
  mac_strobe_t     stb;

  mac_select #(.OP_W(OP_W), .WD_W(WD_W), .AP_W(AP_W)) u_select (
    .actIn(actIn), .wgtIn(wgtIn), .layerWidth(layerWidth), .approxLvl(approxLvl),
    .decompMask(decompMask), .multiplicand(multiplicand), .skip(skip));

  mac_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .startSum(startSum), .skip(skip),
    .decompMask(decompMask), .ready(ready), .done(done), .stb(stb));

  mac_datapath #(.OP_W(OP_W), .ACC_W(ACC_W)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .multiplicand(multiplicand),
    .signIn(signIn), .accOut(accOut));

  // R3: exact mode never splits the operand with more set bits
  p_min_adds_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ready && approxLvl == '0 |-> $countones(decompMask) <= $countones(multiplicand));
endmodule

// File: tb/shift_add_mac_bench.sv
module shift_add_mac_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, signIn = 1'b0, startSum = 1'b0;
  logic [7:0] actIn = '0, wgtIn = '0;
  logic [3:0] layerWidth = '0;
  logic [2:0] approxLvl = '0;
  logic ready, done;
  logic [23:0] accOut;

  typedef struct { logic [23:0] expAcc; int due; string tag; } item_t;
  item_t sb[$];
  int errors = 0, checks = 0, cyc = 0;
  logic [23:0] model = '0;
  bit finished = 0;

  shift_add_mac u_shift_add_mac (.clk(clk), .rstN(rstN), .inValid(inValid), .actIn(actIn),
    .wgtIn(wgtIn), .signIn(signIn), .startSum(startSum), .layerWidth(layerWidth),
    .approxLvl(approxLvl), .ready(ready), .done(done), .accOut(accOut));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pop8(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  // Driver: offer one pair, queue its expected sum and completion cycle
  task automatic doMac(input logic [7:0] a, input logic [7:0] w, input logic s,
                       input logic [3:0] wd, input logic [2:0] ap, input logic st,
                       input string tag);
    logic [7:0] am, wm, ch, ot;
    int ew, k, dr;
    item_t it;
    ew = (wd == 0 || wd > 8) ? 8 : int'(wd);
    am = a; wm = w;
    for (int i = ew; i < 8; i++) begin am[i] = 1'b0; wm[i] = 1'b0; end
    if (pop8(am) < pop8(wm)) begin ch = am; ot = wm; end
    else begin ch = wm; ot = am; end
    dr = 0;
    for (int i = 0; i < 8; i++)
      if (ch[i] && dr < int'(ap)) begin ch[i] = 1'b0; dr++; end
    if (am == 0 || wm == 0) ch = 0;
    k = pop8(ch);
    if (st) model = '0;
    if (s) model = model - 24'(ch * ot);
    else   model = model + 24'(ch * ot);
    @(negedge clk);
    while (!ready) @(negedge clk);
    actIn = a; wgtIn = w; signIn = s; layerWidth = wd; approxLvl = ap; startSum = st;
    inValid = 1'b1;
    @(posedge clk); #1;
    it.expAcc = model; it.due = cyc + k; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    inValid = 1'b0; startSum = 1'b0;
    check({tag, " R2 ready after accept"}, 32'(ready), 32'(k == 0));
  endtask

  // Monitor: compare each finished pair against the scoreboard
  always @(negedge clk) begin
    if (rstN && done && !finished) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected done: actual=1 expected=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " R1 sum"}, 32'(accOut), 32'(it.expAcc));
        check({it.tag, " R2 latency"}, 32'(cyc), 32'(it.due));
        check({it.tag, " R2 ready at done"}, 32'(ready), 32'd1);
      end
    end
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35;
    check("R9 ready at reset", 32'(ready), 32'd1);
    check("R9 done at reset", 32'(done), 32'd0);
    check("R9 acc at reset", 32'(accOut), 32'd0);
    rstN = 1'b1;
    doMac(8'd3, 8'd5, 0, 4'd8, 3'd0, 1, "R3 tie exact");
    doMac(8'd255, 8'd1, 0, 4'd8, 3'd0, 0, "R3 weight sparse");
    doMac(8'h80, 8'hFF, 1, 4'd8, 3'd0, 0, "R1 subtract");
    doMac(8'd0, 8'd77, 0, 4'd8, 3'd0, 0, "R6 zero act");
    doMac(8'hF3, 8'h1E, 0, 4'd4, 3'd0, 0, "R4 width 4");
    doMac(8'h81, 8'h81, 0, 4'd0, 3'd0, 0, "R4 width 0 full");
    doMac(8'hF8, 8'h11, 0, 4'd3, 3'd0, 0, "R4 masked to zero R6");
    doMac(8'h05, 8'h06, 0, 4'd8, 3'd1, 0, "R5 tie approx R3");
    doMac(8'h0F, 8'h03, 0, 4'd8, 3'd2, 0, "R5 all dropped R6");
    doMac(8'hFF, 8'h7F, 1, 4'd8, 3'd3, 0, "R5 drop three");
    doMac(8'd0, 8'd9, 0, 4'd8, 3'd0, 1, "R7 clear on skip");
    doMac(8'd0, 8'd9, 0, 4'd8, 3'd0, 0, "R6 back to back skip");
    doMac(8'd7, 8'd9, 0, 4'd15, 3'd0, 1, "R7 clear then add");
    // R8: offer a pair while busy; it must be ignored
    doMac(8'hFF, 8'hFF, 0, 4'd8, 3'd0, 0, "R8 long pair");
    @(negedge clk);
    actIn = 8'd1; wgtIn = 8'd1; startSum = 1'b1; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; startSum = 1'b0;
    while (!ready) @(negedge clk);
    @(negedge clk);
    check("R8 sum after ignored offer", 32'(accOut), 32'(model));
    @(negedge clk);
    check("R8 sum holds", 32'(accOut), 32'(model));
    for (int n = 0; n < 60; n++)
      doMac(8'($urandom), 8'($urandom), 1'($urandom), 4'($urandom), 3'($urandom),
            ($urandom % 8) == 0, "R5 random");
    repeat (12) @(negedge clk);
    check("R8 scoreboard drained", 32'(sb.size()), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule